// File: doc/BRIEF.md
# Integer Arithmetic and Compare Unit

This unit performs the integer add, subtract and set-on-less-than work of a simple 32-bit processor datapath. One operand comes from the first register port. The second comes either from the second register port or from a 16-bit immediate field, which the unit widens itself. The caller picks sign or zero extension with a separate flag. The instruction decoder drives that flag high for immediate add and for both immediate compares, the unsigned one included.

The "unsigned" add and subtract forms produce exactly the same bits as their plain forms. They differ only in that they never raise the overflow exception flag. Both compares run on the same subtractor: the signed compare uses the difference sign corrected by overflow, and the unsigned compare uses the borrow. The result and the overflow flag are registered, so they appear one clock after the operands are sampled. Negation is expressed as a subtract from a zero operand.

Top module: `ialu_core`

## Requirements
- R1: A synchronous active-high reset clears `result_o` and `ovf_o` to zero. Outside reset, both outputs show the operation sampled at the previous rising clock edge.
- R2: Operation codes 3'b000 (add) and 3'b001 (add, no trap) both return the operand sum modulo 2^DATA_W.
- R3: Operation codes 3'b010 (subtract) and 3'b011 (subtract, no trap) both return the first operand minus the second operand, modulo 2^DATA_W.
- R4: For code 3'b000, `ovf_o` is 1 exactly when both operands have the same sign bit and the sum's sign bit differs from it.
- R5: For code 3'b010, `ovf_o` is 1 exactly when the operand sign bits differ and the difference's sign bit differs from that of the first operand.
- R6: `ovf_o` is 0 for codes 3'b001, 3'b011, 3'b100 and 3'b101, whatever the operand values.
- R7: Code 3'b100 returns 1 when the first operand is less than the second as two's-complement numbers, and 0 otherwise. Bits above bit 0 are always zero.
- R8: Code 3'b101 returns 1 when the first operand is less than the second as unsigned magnitudes, and 0 otherwise. Bits above bit 0 are always zero.
- R9: With `use_imm_i`=1, the second operand is `imm_i` widened to DATA_W. If `imm_sext_i`=1, bit IMM_W-1 is copied into every upper bit; if it is 0, the upper bits are filled with zeros. `b_i` is then ignored.
- R10: Codes 3'b110 and 3'b111 return a zero result with `ovf_o`=0.
- R11: Subtracting an operand from a zero first operand gives its two's-complement negation, not its bitwise inverse. Negating the most negative value returns that value and flags overflow under code 3'b010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code |
| use_imm_i | input | 1 | 1 selects the widened immediate as the second operand |
| imm_sext_i | input | 1 | 1 sign-extends the immediate, 0 zero-extends it |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second register operand |
| imm_i | input | IMM_W | Immediate field |
| result_o | output | DATA_W | Registered result |
| ovf_o | output | 1 | Registered signed-overflow exception flag |

## Verification
The bench builds the unit with its defaults: DATA_W=32 and IMM_W=16. With these values the sign boundary between 0x7FFFFFFF and 0x80000000 can be reached directly, as can immediate bit 15, where sign and zero extension diverge. Random operands are biased toward zero, one, all-ones and the two sign-edge values. This makes overflow, borrow and signed-versus-unsigned compare disagreements frequent rather than rare. Directed cases cover negation of the most negative value, immediate compares against a sign-extended 0xFFFF, and a reset asserted while live operands are applied.

// File: rtl/ialu_pkg.sv
package ialu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDU = 3'd1,
    OP_SUB  = 3'd2,
    OP_SUBU = 3'd3,
    OP_SLT  = 3'd4,
    OP_SLTU = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_SUM  = 2'd0,
    SEL_LTS  = 2'd1,
    SEL_LTU  = 2'd2,
    SEL_ZERO = 2'd3
  } res_sel_e;

  typedef struct packed {
    logic     subtract;
    logic     trap_en;
    res_sel_e sel;
  } alu_ctrl_t;

endpackage

// File: rtl/ialu_decode.sv
module ialu_decode
  import ialu_pkg::*;
(
  input  logic [2:0] op_i,
  output alu_ctrl_t  ctrl_o
);

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  always_comb begin
    ctrl_o = '{subtract: 1'b0, trap_en: 1'b0, sel: SEL_ZERO};
    unique case (op)
      OP_ADD:  ctrl_o = '{subtract: 1'b0, trap_en: 1'b1, sel: SEL_SUM};
      OP_ADDU: ctrl_o = '{subtract: 1'b0, trap_en: 1'b0, sel: SEL_SUM};
      OP_SUB:  ctrl_o = '{subtract: 1'b1, trap_en: 1'b1, sel: SEL_SUM};
      OP_SUBU: ctrl_o = '{subtract: 1'b1, trap_en: 1'b0, sel: SEL_SUM};
      OP_SLT:  ctrl_o = '{subtract: 1'b1, trap_en: 1'b0, sel: SEL_LTS};
      OP_SLTU: ctrl_o = '{subtract: 1'b1, trap_en: 1'b0, sel: SEL_LTU};
      default: ctrl_o = '{subtract: 1'b0, trap_en: 1'b0, sel: SEL_ZERO};
    endcase
  end

endmodule

// File: rtl/ialu_imm_ext.sv
module ialu_imm_ext #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              sext_i,
  output logic [DATA_W-1:0] ext_o
);

  localparam int EXT_W = DATA_W - IMM_W;

  generate
    if (EXT_W > 0) begin : g_widen
      logic fill;
      assign fill  = sext_i & imm_i[IMM_W-1];
      assign ext_o = {{EXT_W{fill}}, imm_i};
    end else begin : g_pass
      logic unused_sext;
      assign unused_sext = sext_i;
      assign ext_o       = imm_i[DATA_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/ialu_addsub.sv
module ialu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              ovf_o
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  assign b_eff  = b_i ^ {DATA_W{sub_i}};
  assign wide   = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
  assign sum_o  = wide[DATA_W-1:0];
  assign cout_o = wide[DATA_W];
  assign ovf_o  = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);

endmodule

// File: rtl/ialu_cmp.sv
module ialu_cmp (
  input  logic diff_sign_i,
  input  logic diff_ovf_i,
  input  logic carry_i,
  output logic lt_signed_o,
  output logic lt_unsigned_o
);

  assign lt_signed_o   = diff_sign_i ^ diff_ovf_i;
  assign lt_unsigned_o = ~carry_i;

endmodule

// File: rtl/ialu_core.sv
module ialu_core
  import ialu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_i,
  input  logic              use_imm_i,
  input  logic              imm_sext_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              ovf_o
);

  localparam int MSB = DATA_W - 1;

  alu_ctrl_t         ctrl;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] b_sel;
  logic [DATA_W-1:0] sum;
  logic              carry;
  logic              ovf_raw;
  logic              lt_s;
  logic              lt_u;
  logic [DATA_W-1:0] res_next;

  ialu_decode u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  ialu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
    .imm_i  (imm_i),
    .sext_i (imm_sext_i),
    .ext_o  (imm_ext)
  );

  assign b_sel = use_imm_i ? imm_ext : b_i;

  ialu_addsub #(.DATA_W(DATA_W)) u_as (
    .a_i    (a_i),
    .b_i    (b_sel),
    .sub_i  (ctrl.subtract),
    .sum_o  (sum),
    .cout_o (carry),
    .ovf_o  (ovf_raw)
  );

  ialu_cmp u_cmp (
    .diff_sign_i   (sum[MSB]),
    .diff_ovf_i    (ovf_raw),
    .carry_i       (carry),
    .lt_signed_o   (lt_s),
    .lt_unsigned_o (lt_u)
  );

  always_comb begin
    unique case (ctrl.sel)
      SEL_SUM: res_next = sum;
      SEL_LTS: res_next = {{(DATA_W-1){1'b0}}, lt_s};
      SEL_LTU: res_next = {{(DATA_W-1){1'b0}}, lt_u};
      default: res_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      ovf_o    <= 1'b0;
    end else begin
      result_o <= res_next;
      ovf_o    <= ovf_raw & ctrl.trap_en;
    end
  end

endmodule

// File: rtl/ialu_core_chk.sv
module ialu_core_chk
  import ialu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        op_i,
  input logic              use_imm_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [DATA_W-1:0] result_o,
  input logic              ovf_o
);

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (result_o == '0 && !ovf_o));

  // R4, R5, R6
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> ($past(op_i) == OP_ADD || $past(op_i) == OP_SUB));

  // R2
  p_addu_sum_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_ADDU && !$past(use_imm_i))
      |-> result_o == $past(a_i) + $past(b_i));

  // R3
  p_subu_diff_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_SUBU && !$past(use_imm_i))
      |-> result_o == $past(a_i) - $past(b_i));

  // R7
  p_cmp_narrow_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == OP_SLT || $past(op_i) == OP_SLTU))
      |-> result_o[DATA_W-1:1] == '0);

  // R8
  p_sltu_equal_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_SLTU && !$past(use_imm_i) && $past(a_i) == $past(b_i))
      |-> result_o == '0);

  // R10
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) >= 3'd6) |-> (result_o == '0 && !ovf_o));

endmodule

bind ialu_core ialu_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_i      (op_i),
  .use_imm_i (use_imm_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .result_o  (result_o),
  .ovf_o     (ovf_o)
);

// File: tb/ialu_core_tb.sv
`timescale 1ns/1ps
module ialu_core_tb;

  localparam int DW = 32;
  localparam int IW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    op_i = '0;
  logic          use_imm_i = 1'b0;
  logic          imm_sext_i = 1'b0;
  logic [DW-1:0] a_i = '0;
  logic [DW-1:0] b_i = '0;
  logic [IW-1:0] imm_i = '0;
  logic [DW-1:0] result_o;
  logic          ovf_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ialu_core #(.DATA_W(DW), .IMM_W(IW)) u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .use_imm_i(use_imm_i),
    .imm_sext_i(imm_sext_i), .a_i(a_i), .b_i(b_i), .imm_i(imm_i),
    .result_o(result_o), .ovf_o(ovf_o)
  );

  function automatic logic [DW:0] model(input logic [2:0] op, input logic [DW-1:0] a,
                                        input logic [DW-1:0] b, input logic ui,
                                        input logic se, input logic [IW-1:0] im);
    logic [DW-1:0] bv, r;
    logic          v;
    bv = ui ? (se ? {{(DW-IW){im[IW-1]}}, im} : {{(DW-IW){1'b0}}, im}) : b;
    r  = '0;
    v  = 1'b0;
    case (op)
      3'd0, 3'd1: begin
        r = a + bv;
        v = (op == 3'd0) && (a[DW-1] == bv[DW-1]) && (r[DW-1] != a[DW-1]);
      end
      3'd2, 3'd3: begin
        r = a - bv;
        v = (op == 3'd2) && (a[DW-1] != bv[DW-1]) && (r[DW-1] != a[DW-1]);
      end
      3'd4: r = {{(DW-1){1'b0}}, ($signed(a) < $signed(bv))};
      3'd5: r = {{(DW-1){1'b0}}, (a < bv)};
      default: r = '0;
    endcase
    return {v, r};
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2/R4";
      3'd1: return "R2/R6";
      3'd2: return "R3/R5";
      3'd3: return "R3/R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [DW-1:0] pick();
    case ($urandom_range(0, 5))
      0: return '0;
      1: return {{(DW-1){1'b0}}, 1'b1};
      2: return '1;
      3: return {1'b0, {(DW-1){1'b1}}};
      4: return {1'b1, {(DW-1){1'b0}}};
      default: return $urandom();
    endcase
  endfunction

  task automatic compare(input string req, input logic [DW-1:0] exp_r, input logic exp_v);
    n_chk++;
    if (result_o !== exp_r || ovf_o !== exp_v) begin
      n_fail++;
      $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b",
               req, result_o, ovf_o, exp_r, exp_v);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic ui, input logic se, input logic [IW-1:0] im,
                       input string req);
    logic [DW:0] e;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; use_imm_i = ui; imm_sext_i = se; imm_i = im;
    e = model(op, a, b, ui, se, im);
    @(posedge clk);
    @(negedge clk);
    compare(req, e[DW-1:0], e[DW]);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++;
        $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1a1b));
    repeat (3) @(negedge clk);
    compare("R1 reset state", '0, 1'b0);
    rst = 1'b0;

    apply(3'd0, 32'h7FFFFFFF, 32'h1, 0, 0, '0, "R4 pos overflow");
    apply(3'd1, 32'h7FFFFFFF, 32'h1, 0, 0, '0, "R2 R6 addu same bits");
    apply(3'd0, 32'h80000000, 32'h80000000, 0, 0, '0, "R4 neg overflow");
    apply(3'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0, '0, "R4 no overflow");
    apply(3'd2, 32'h80000000, 32'h1, 0, 0, '0, "R5 sub overflow");
    apply(3'd3, 32'h80000000, 32'h1, 0, 0, '0, "R3 R6 subu same bits");
    apply(3'd2, 32'h0, 32'h5, 0, 0, '0, "R11 negate five");
    apply(3'd2, 32'h0, 32'h80000000, 0, 0, '0, "R11 negate most negative");
    apply(3'd4, 32'hFFFFFFFF, 32'h1, 0, 0, '0, "R7 signed less");
    apply(3'd5, 32'hFFFFFFFF, 32'h1, 0, 0, '0, "R8 unsigned not less");
    apply(3'd4, 32'h0, 32'h0, 1, 1, 16'hFFFF, "R9 R7 imm sext compare");
    apply(3'd5, 32'h5, 32'h0, 1, 1, 16'hFFFF, "R9 R8 imm sext unsigned compare");
    apply(3'd1, 32'h0, 32'hDEADBEEF, 1, 0, 16'h8000, "R9 zero extend");
    apply(3'd1, 32'h0, 32'hDEADBEEF, 1, 1, 16'h8000, "R9 sign extend");
    apply(3'd0, 32'h7FFFFFFF, 32'h0, 1, 1, 16'h0001, "R4 R9 addi overflow");
    apply(3'd6, 32'h7FFFFFFF, 32'h1, 0, 0, '0, "R10 reserved six");
    apply(3'd7, 32'h80000000, 32'h1, 0, 0, '0, "R10 reserved seven");

    // R1: reset while live operands are applied
    @(negedge clk);
    op_i = 3'd0; a_i = 32'h7FFFFFFF; b_i = 32'h1; use_imm_i = 0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    compare("R1 mid-run reset", '0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] op;
      logic       ui;
      op = 3'($urandom_range(0, 7));
      ui = ($urandom_range(0, 3) == 0);
      apply(op, pick(), pick(), ui, 1'($urandom_range(0, 1)), 16'($urandom()), tag_of(op));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule